// File: doc/BRIEF.md
# Parallel Backplane Bus Slave Interface

This block is the slave end of an asynchronous parallel backplane bus that uses address-strobe, data-strobe and acknowledge signalling, all active low. When the address strobe falls, the block checks the address lines and a 6-bit address modifier against two configurable base addresses, one for 32-bit addressing and one for 24-bit addressing. If both match, it serves the cycle from a small internal register file. If either does not match, the block stays silent.

Single cycles move 8, 16 or 32 bits. The size and the byte position come from the two data strobes, the long-word line and address bit 1; the bus has no address bit 0. Storage is big endian, so byte offset 0 is the most significant byte of a stored word. Block cycles move 32-bit words. The address lines stay frozen for the whole burst, and an internal word counter steps after every acknowledged beat. A request the block is addressed for but cannot perform ends with a bus error instead of an acknowledge. All strobes pass through two-flop synchronizers before a four-state handshake machine acts on them.

Top module: `pbus_slave`

## Requirements
- R1: After reset, the acknowledge and bus-error outputs are high (inactive) and the data output enable is low.
- R2: Accepted modifier codes are 0x09 and 0x0D (32-bit address, single), 0x0B and 0x0F (32-bit address, block), 0x39 and 0x3D (24-bit address, single), and 0x3B and 0x3F (24-bit address, block). With a 32-bit code, address bits 31 down to the window width must equal the 32-bit base. With a 24-bit code only bits 23 down to the window width are compared with the 24-bit base, and bits 31..24 are ignored. Both address widths reach the same register file.
- R3: A cycle whose address or modifier does not match gets neither acknowledge nor bus error, and a write in such a cycle leaves every register unchanged.
- R4: The block answers a falling data strobe with exactly one of acknowledge or bus error, never both. It holds that answer while any data strobe stays low and drops it after both data strobes are high.
- R5: A 32-bit transfer is long-word low, both data strobes low and address bit 1 low. It moves the whole word on data bits 31..0.
- R6: A 16-bit transfer is long-word high with both data strobes low, and it uses data bits 15..0. Address bit 1 low selects byte offsets 0 and 1, the upper half of the word. Address bit 1 high selects offsets 2 and 3.
- R7: An 8-bit transfer has long-word high and one data strobe low. Data strobe 1 alone selects the even byte on data bits 15..8, and data strobe 0 alone selects the odd byte on data bits 7..0. After 0x11223344 is written at offset 0, a byte read at offset 0 returns 0x1100 and a byte read at offset 3 returns 0x0044. Unused lanes read zero.
- R8: A bus error answers a long-word cycle that has address bit 1 high or only one data strobe low, and a block cycle that is not 32-bit. In all these cases the register file is not written.
- R9: In a block cycle the word index starts at the one given by the address. It advances by one after every acknowledged beat and wraps at the end of the register window.
- R10: The data output enable is high only while an acknowledge answers a read, and the read data stays stable for as long as the acknowledge is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe for the odd byte lane, active low |
| bus_ds1_n | input | 1 | Data strobe for the even byte lane, active low |
| bus_lword_n | input | 1 | Long-word select, active low |
| bus_write_n | input | 1 | Direction, low for write |
| bus_addr | input | 31 | Address lines 31..1 |
| bus_am | input | 6 | Address modifier code |
| bus_data_in | input | 32 | Data from the bus |
| bus_data_out | output | 32 | Read data toward the bus |
| bus_data_oe | output | 1 | Enable for the read data drivers |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| bus_berr_n | output | 1 | Bus error, active low |

## Verification
The properties assume that the master behaves. It sets address, modifier, direction and long-word before it drops the address strobe and holds them until the strobe rises. It keeps every data strobe low until it sees an answer, and it raises the address strobe only after both data strobes are high and the answer is gone. The bench stays within these rules because it drives every strobe edge from one task, on a falling clock edge. It waits on the answer at the ports before it takes the next step. For cycles that should get no answer, it holds the data strobe for a fixed window and then releases it.

// File: rtl/pbus_pkg.sv
// Shared types for the backplane bus slave: handshake states and the
// classification of an address modifier code.
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACK,
        ST_WAIT_DS_RELEASE
    } hs_state_t;

    typedef struct packed {
        logic valid;   // code is one the slave serves
        logic wide;    // 32-bit address (else 24-bit)
        logic blk;     // block transfer (else single cycle)
    } am_class_t;

    // Classify a modifier: bits 5..3 give the address width, bit 2 is the
    // privilege level (either accepted), bits 1..0 give single or block.
    function automatic am_class_t classify_am(input logic [5:0] am);
        am_class_t c;
        c.wide  = (am[5:3] == 3'b001);
        c.blk   = (am[1:0] == 2'b11);
        c.valid = ((am[5:3] == 3'b001) || (am[5:3] == 3'b111)) &&
                  ((am[1:0] == 2'b01) || (am[1:0] == 2'b11));
        return c;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
// Two-flop synchronizer for a vector of asynchronous strobes.
// Assumes each bit is an independent level; no bus coherency is implied.
module pbus_sync #(
    parameter int          W         = 3,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RESET_VAL;
            q_sync <= RESET_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/pbus_decode.sv
// Address and modifier match. Purely combinational; assumes the address
// and modifier are stable while the address strobe is low.
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int          WIN_BITS = 5,
    parameter logic [31:0] BASE_A32 = 32'h8000_0000,
    parameter logic [23:0] BASE_A24 = 24'h40_0000
) (
    input  logic [31:WIN_BITS] addr_hi,
    input  logic [5:0]         am,
    output logic               hit,
    output logic               blk
);
    am_class_t cls;
    logic      match32;
    logic      match24;

    // Compare the upper address bits against the base chosen by the code.
    always_comb begin
        cls     = classify_am(am);
        match32 = (addr_hi[31:WIN_BITS] == BASE_A32[31:WIN_BITS]);
        match24 = (addr_hi[23:WIN_BITS] == BASE_A24[23:WIN_BITS]);
        hit     = cls.valid && (cls.wide ? match32 : match24);
        blk     = cls.blk;
    end
endmodule

// File: rtl/pbus_lanes.sv
// Byte-lane steering between the bus data lines and a big-endian word.
// Byte offset 0 is word bits 31..24. Also flags illegal size encodings.
module pbus_lanes (
    input  logic        lword_n,
    input  logic        a1,
    input  logic        ds0_n,
    input  logic        ds1_n,
    input  logic [31:0] bus_wdata,
    input  logic [31:0] word_rdata,
    output logic [3:0]  be,
    output logic [31:0] word_wdata,
    output logic [31:0] bus_rdata,
    output logic        bad_size
);
    logic [15:0] half;
    logic [15:0] lane_mask;

    // Map strobes, long-word and A1 onto byte enables and data positions.
    always_comb begin
        lane_mask = {{8{~ds1_n}}, {8{~ds0_n}}};
        half      = a1 ? word_rdata[15:0] : word_rdata[31:16];
        bad_size  = !lword_n && (a1 || ds0_n || ds1_n);
        if (!lword_n) begin
            be         = 4'b1111;
            word_wdata = bus_wdata;
            bus_rdata  = word_rdata;
        end else begin
            be         = a1 ? {2'b00, ~ds1_n, ~ds0_n} : {~ds1_n, ~ds0_n, 2'b00};
            word_wdata = a1 ? {16'h0000, bus_wdata[15:0]} : {bus_wdata[15:0], 16'h0000};
            bus_rdata  = {16'h0000, half & lane_mask};
        end
    end
endmodule

// File: rtl/pbus_regfile.sv
// Small register file with per-byte write enables and combinational read.
module pbus_regfile #(
    parameter int WORDS = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            // Update one byte of one word when selected and enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[w][8*b +: 8] <= 8'h00;
                else if (we && be[b] && (waddr == AW'(w)))
                    mem[w][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pbus_slave.sv
// Slave interface for an asynchronous parallel backplane bus.
// Assumes the master holds address, modifier, direction and long-word
// stable while the address strobe is low, and data stable while a data
// strobe is low. Strobes are synchronized; the answer is registered.
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int          REG_WORDS = 8,
    parameter logic [31:0] BASE_A32  = 32'h8000_0000,
    parameter logic [23:0] BASE_A24  = 24'h40_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_as_n,
    input  logic        bus_ds0_n,
    input  logic        bus_ds1_n,
    input  logic        bus_lword_n,
    input  logic        bus_write_n,
    input  logic [31:1] bus_addr,
    input  logic [5:0]  bus_am,
    input  logic [31:0] bus_data_in,
    output logic [31:0] bus_data_out,
    output logic        bus_data_oe,
    output logic        bus_dtack_n,
    output logic        bus_berr_n
);
    localparam int WIDX_W   = $clog2(REG_WORDS);
    localparam int WIN_BITS = WIDX_W + 2;

    hs_state_t          state_q;
    logic [2:0]         strobe_s;
    logic               as_s, ds1_s, ds0_s, ds_any;
    logic               hit, blk;
    logic               sel_q, blk_q, rd_q, lword_q, a1_q;
    logic [WIDX_W-1:0]  widx_q;
    logic               dtack_q, berr_q, oe_q;
    logic [31:0]        dout_q;
    logic [31:0]        rd_word, word_wdata, bus_rdata;
    logic [3:0]         be;
    logic               bad_size, xfer_err, we;

    pbus_sync #(.W(3), .RESET_VAL(3'b111)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({bus_as_n, bus_ds1_n, bus_ds0_n}),
        .q_sync (strobe_s)
    );

    assign as_s   = strobe_s[2];
    assign ds1_s  = strobe_s[1];
    assign ds0_s  = strobe_s[0];
    assign ds_any = !ds0_s || !ds1_s;

    pbus_decode #(.WIN_BITS(WIN_BITS), .BASE_A32(BASE_A32), .BASE_A24(BASE_A24)) i_decode (
        .addr_hi(bus_addr[31:WIN_BITS]),
        .am     (bus_am),
        .hit    (hit),
        .blk    (blk)
    );

    pbus_lanes i_lanes (
        .lword_n   (lword_q),
        .a1        (a1_q),
        .ds0_n     (ds0_s),
        .ds1_n     (ds1_s),
        .bus_wdata (bus_data_in),
        .word_rdata(rd_word),
        .be        (be),
        .word_wdata(word_wdata),
        .bus_rdata (bus_rdata),
        .bad_size  (bad_size)
    );

    // A block beat must be 32 bits; other size faults come from the lanes.
    assign xfer_err = bad_size || (blk_q && lword_q);
    assign we       = (state_q == ST_ACK) && !as_s && ds_any && !xfer_err && !rd_q;

    pbus_regfile #(.WORDS(REG_WORDS)) i_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .be   (be),
        .waddr(widx_q),
        .wdata(word_wdata),
        .raddr(widx_q),
        .rdata(rd_word)
    );

    // Handshake machine: decode on strobe, answer each data strobe, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            blk_q   <= 1'b0;
            rd_q    <= 1'b0;
            lword_q <= 1'b1;
            a1_q    <= 1'b0;
            widx_q  <= '0;
            dtack_q <= 1'b0;
            berr_q  <= 1'b0;
            oe_q    <= 1'b0;
            dout_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!as_s) state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    sel_q   <= hit;
                    blk_q   <= blk;
                    rd_q    <= bus_write_n;
                    lword_q <= bus_lword_n;
                    a1_q    <= bus_addr[1];
                    widx_q  <= bus_addr[WIN_BITS-1:2];
                    state_q <= hit ? ST_ACK : ST_WAIT_DS_RELEASE;
                end
                ST_ACK: begin
                    if (as_s) begin
                        state_q <= ST_IDLE;
                    end else if (ds_any) begin
                        if (xfer_err) begin
                            berr_q <= 1'b1;
                        end else begin
                            dtack_q <= 1'b1;
                            oe_q    <= rd_q;
                            dout_q  <= rd_q ? bus_rdata : 32'h0;
                        end
                        state_q <= ST_WAIT_DS_RELEASE;
                    end
                end
                ST_WAIT_DS_RELEASE: begin
                    if (!ds_any) begin
                        dtack_q <= 1'b0;
                        berr_q  <= 1'b0;
                        oe_q    <= 1'b0;
                        if (as_s) begin
                            state_q <= ST_IDLE;
                        end else if (sel_q && blk_q && dtack_q) begin
                            widx_q  <= widx_q + 1'b1;
                            state_q <= ST_ACK;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_dtack_n  = !dtack_q;
    assign bus_berr_n   = !berr_q;
    assign bus_data_oe  = oe_q;
    assign bus_data_out = dout_q;
endmodule

// File: rtl/pbus_slave_checker.sv
// Protocol properties observed at the ports of pbus_slave.
// Assumes a well-behaved master (see the brief).
module pbus_slave_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_as_n,
    input logic        bus_ds0_n,
    input logic        bus_ds1_n,
    input logic        bus_write_n,
    input logic [31:0] bus_data_out,
    input logic        bus_data_oe,
    input logic        bus_dtack_n,
    input logic        bus_berr_n
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_dtack_n && !bus_berr_n));                                   // R4

    AST_ANSWER_NEEDS_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_dtack_n) || $fell(bus_berr_n)) |-> (!bus_ds0_n || !bus_ds1_n)); // R4

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dtack_n && (!bus_ds0_n || !bus_ds1_n)) |=> !bus_dtack_n);    // R4

    AST_RELEASE_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds0_n && bus_ds1_n && $past(bus_ds0_n && bus_ds1_n) &&
         $past(bus_ds0_n && bus_ds1_n, 2) && $past(bus_ds0_n && bus_ds1_n, 3))
        |-> (bus_dtack_n && bus_berr_n));                                  // R4

    AST_QUIET_WITHOUT_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as_n && $past(bus_as_n) && $past(bus_as_n, 2) && $past(bus_as_n, 3) &&
         $past(bus_as_n, 4)) |-> (bus_dtack_n && bus_berr_n));             // R3

    AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (!bus_dtack_n && bus_write_n));                    // R10

    AST_READ_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));    // R10
endmodule

bind pbus_slave pbus_slave_checker i_pbus_slave_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_as_n    (bus_as_n),
    .bus_ds0_n   (bus_ds0_n),
    .bus_ds1_n   (bus_ds1_n),
    .bus_write_n (bus_write_n),
    .bus_data_out(bus_data_out),
    .bus_data_oe (bus_data_oe),
    .bus_dtack_n (bus_dtack_n),
    .bus_berr_n  (bus_berr_n)
);

// File: tb/test_pbus_slave.sv
// Scoreboard bench: bus tasks queue the expected answer of each data
// strobe; a monitor pops and compares when an answer appears at the ports.
module test_pbus_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_as_n = 1'b1, bus_ds0_n = 1'b1, bus_ds1_n = 1'b1;
    logic        bus_lword_n = 1'b1, bus_write_n = 1'b1;
    logic [31:1] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic [31:0] bus_data_in = '0;
    logic [31:0] bus_data_out;
    logic        bus_data_oe, bus_dtack_n, bus_berr_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        err;
        logic        rd;
        logic [31:0] data;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    pbus_slave i_pbus_slave (
        .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_ds0_n(bus_ds0_n),
        .bus_ds1_n(bus_ds1_n), .bus_lword_n(bus_lword_n), .bus_write_n(bus_write_n),
        .bus_addr(bus_addr), .bus_am(bus_am), .bus_data_in(bus_data_in),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_dtack_n(bus_dtack_n), .bus_berr_n(bus_berr_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each new answer against the head of the queue.
    logic prev_resp = 1'b0;
    always @(negedge clk) begin
        logic resp;
        resp = rst_n && (!bus_dtack_n || !bus_berr_n);
        if (resp && !prev_resp) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected answer R3", {30'h0, bus_dtack_n, bus_berr_n}, 32'h3);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.err)
                    check(!bus_berr_n && bus_dtack_n, t, {30'h0, bus_dtack_n, bus_berr_n}, 32'h2);
                else if (e.rd)
                    check(!bus_dtack_n && bus_berr_n && bus_data_oe && bus_data_out == e.data,
                          t, bus_data_out, e.data);
                else
                    check(!bus_dtack_n && bus_berr_n && !bus_data_oe, t,
                          {30'h0, bus_dtack_n, bus_berr_n}, 32'h1);
            end
        end
        prev_resp = resp;
    end

    task automatic cyc_start(input logic [31:0] a, input logic [5:0] am,
                             input logic lw_n, input logic wr_n);
        @(negedge clk);
        bus_addr    = a[31:1];
        bus_am      = am;
        bus_lword_n = lw_n;
        bus_write_n = wr_n;
        @(negedge clk);
        bus_as_n = 1'b0;
    endtask

    task automatic cyc_end();
        @(negedge clk);
        bus_as_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // One data strobe with a queued expectation; waits for answer and release.
    task automatic beat(input logic d1_n, input logic d0_n, input logic [31:0] wd,
                        input logic exp_err, input logic [31:0] exp_d, input string tag);
        exp_t e;
        int   n;
        e.err = exp_err; e.rd = bus_write_n; e.data = exp_d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_data_in = wd;
        @(negedge clk);
        bus_ds1_n = d1_n;
        bus_ds0_n = d0_n;
        n = 0;
        while (bus_dtack_n && bus_berr_n && n < 40) begin @(negedge clk); n++; end
        if (n >= 40) begin
            check(1'b0, {tag, " no answer"}, 32'h0, 32'h1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        @(negedge clk);
        bus_ds1_n = 1'b1;
        bus_ds0_n = 1'b1;
        n = 0;
        while (!(bus_dtack_n && bus_berr_n) && n < 40) begin @(negedge clk); n++; end
        check(bus_dtack_n && bus_berr_n, {tag, " release R4"}, {30'h0, bus_dtack_n, bus_berr_n}, 32'h3);
    endtask

    // A data strobe that must get no answer in a fixed window.
    task automatic silent_beat(input logic [31:0] wd, input string tag);
        bit quiet;
        quiet = 1'b1;
        bus_data_in = wd;
        @(negedge clk);
        bus_ds1_n = 1'b0;
        bus_ds0_n = 1'b0;
        repeat (15) begin
            @(negedge clk);
            if (!bus_dtack_n || !bus_berr_n) quiet = 1'b0;
        end
        check(quiet, tag, {30'h0, bus_dtack_n, bus_berr_n}, 32'h3);
        bus_ds1_n = 1'b1;
        bus_ds0_n = 1'b1;
    endtask

    task automatic wr32(input logic [31:0] a, input logic [5:0] am, input logic [31:0] d, input string tag);
        cyc_start(a, am, 1'b0, 1'b0);
        beat(1'b0, 1'b0, d, 1'b0, 32'h0, tag);
        cyc_end();
    endtask

    task automatic rd32(input logic [31:0] a, input logic [5:0] am, input logic [31:0] d, input string tag);
        cyc_start(a, am, 1'b0, 1'b1);
        beat(1'b0, 1'b0, 32'h0, 1'b0, d, tag);
        cyc_end();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(bus_dtack_n && bus_berr_n && !bus_data_oe, "R1 reset state",
              {29'h0, bus_dtack_n, bus_berr_n, bus_data_oe}, 32'h6);

        // R5 / R2: 32-bit write then read, user and supervisor codes
        wr32(32'h8000_0000, 6'h09, 32'h1122_3344, "R5 write32");
        rd32(32'h8000_0000, 6'h0D, 32'h1122_3344, "R5 read32 R2");

        // R7: big-endian byte reads
        cyc_start(32'h8000_0000, 6'h09, 1'b1, 1'b1);
        beat(1'b0, 1'b1, 32'h0, 1'b0, 32'h0000_1100, "R7 byte0 read");
        cyc_end();
        cyc_start(32'h8000_0002, 6'h09, 1'b1, 1'b1);
        beat(1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_0044, "R7 byte3 read");
        cyc_end();

        // R6: 16-bit write to the lower half, then R7 byte write at offset 0
        wr32(32'h8000_0008, 6'h09, 32'hA5A5_A5A5, "R5 write32 word2");
        cyc_start(32'h8000_000A, 6'h0D, 1'b1, 1'b0);
        beat(1'b0, 1'b0, 32'h0000_BEEF, 1'b0, 32'h0, "R6 write16 A1=1");
        cyc_end();
        rd32(32'h8000_0008, 6'h09, 32'hA5A5_BEEF, "R6 half merge");
        cyc_start(32'h8000_0008, 6'h09, 1'b1, 1'b0);
        beat(1'b0, 1'b1, 32'h0000_7700, 1'b0, 32'h0, "R7 write byte0");
        cyc_end();
        cyc_start(32'h8000_0008, 6'h09, 1'b1, 1'b1);
        beat(1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_77A5, "R6 read16 A1=0");
        cyc_end();

        // R2: 24-bit addressing shares the register file; upper bits ignored
        wr32(32'h0040_000C, 6'h39, 32'hCAFE_F00D, "R2 a24 write");
        rd32(32'h8000_000C, 6'h09, 32'hCAFE_F00D, "R2 a24 alias read");
        rd32(32'hFF40_000C, 6'h3D, 32'hCAFE_F00D, "R2 a24 upper ignored");

        // R8: misaligned long word, long word with one strobe
        cyc_start(32'h8000_0002, 6'h09, 1'b0, 1'b0);
        beat(1'b0, 1'b0, 32'hDEAD_DEAD, 1'b1, 32'h0, "R8 lword A1=1");
        cyc_end();
        cyc_start(32'h8000_0000, 6'h09, 1'b0, 1'b0);
        beat(1'b1, 1'b0, 32'hDEAD_DEAD, 1'b1, 32'h0, "R8 lword one strobe");
        cyc_end();
        rd32(32'h8000_0000, 6'h09, 32'h1122_3344, "R8 no write on error");

        // R3: wrong address, wrong modifier: no answer, no write
        cyc_start(32'h9000_0000, 6'h09, 1'b0, 1'b0);
        silent_beat(32'h0BAD_0BAD, "R3 address miss");
        cyc_end();
        cyc_start(32'h8000_0000, 6'h29, 1'b0, 1'b0);
        silent_beat(32'h0BAD_0BAD, "R3 modifier miss");
        cyc_end();
        rd32(32'h8000_0000, 6'h09, 32'h1122_3344, "R3 register untouched");

        // R9: block write from word 6 wraps to word 0; block read back
        cyc_start(32'h8000_0018, 6'h0B, 1'b0, 1'b0);
        beat(1'b0, 1'b0, 32'h0000_0001, 1'b0, 32'h0, "R9 blk write 0");
        beat(1'b0, 1'b0, 32'h0000_0002, 1'b0, 32'h0, "R9 blk write 1");
        beat(1'b0, 1'b0, 32'h0000_0003, 1'b0, 32'h0, "R9 blk write 2");
        cyc_end();
        cyc_start(32'h0040_0018, 6'h3F, 1'b0, 1'b1);
        beat(1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0001, "R9 blk read 0 R10");
        beat(1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0002, "R9 blk read 1 R10");
        beat(1'b0, 1'b0, 32'h0, 1'b0, 32'h0000_0003, "R9 blk read 2 R10");
        cyc_end();
        rd32(32'h8000_0000, 6'h09, 32'h0000_0003, "R9 wrap to word0");
        rd32(32'h8000_001C, 6'h09, 32'h0000_0002, "R9 word7");

        // R8: block cycle that is not 32-bit
        cyc_start(32'h8000_0010, 6'h0F, 1'b1, 1'b0);
        beat(1'b0, 1'b0, 32'h0000_FFFF, 1'b1, 32'h0, "R8 block not 32-bit");
        cyc_end();
        rd32(32'h8000_0010, 6'h09, 32'h0000_0000, "R8 block error no write");

        // R10: enable stays low after a write answer and when idle
        check(!bus_data_oe, "R10 enable idle", {31'h0, bus_data_oe}, 32'h0);
        check(exp_q.size() == 0, "R4 all answers seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule